// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block is the front end for eight external interrupt pins and one non-maskable interrupt pin. Every pin first passes through a two-stage synchronizer. A per-pin detector then watches for a sense condition that software selects. When the condition is met, a pending flag is latched. Each pending flag drives its own request line toward a parent interrupt controller. The parent does the masking, prioritising and vectoring.

Software reaches the block over a plain 16-bit register bus. One register holds a 2-bit sense field per pin, and one register holds the pending flags. A third register controls the non-maskable pin and reports its state. A pending flag is cleared by writing zero to its bit. A one written to any bit leaves that flag as it is, so a handler can clear its own flag without a read-modify-write and without losing flags raised meanwhile.

Top module: `ext_irq_sense`

## Requirements
- R1: After reset every pending flag and the NMI flag are 0, every sense field is 0 and the NMI edge select is 0. The request register (offset 4) and the sense register (offset 2) read 0, and the NMI register (offset 0) reads 16'h8000 while the NMI pin is high.
- R2: The sense register at offset 2 is read/write. Pin n uses bits [2n+1:2n] of it.
- R3: Sense code 0 (low level) sets pin n's flag on every clock while the synchronized pin is low. A clear written while the pin stays low leaves the flag set. Once the pin is high, a clear takes effect.
- R4: Sense code 1 sets the flag on a high-to-low transition of the synchronized pin.
- R5: Sense code 2 sets the flag on a low-to-high transition, and only on that transition.
- R6: Sense code 3 sets the flag on either transition.
- R7: The request register at offset 4 returns pending flag n at bit n and 0 in bits 15:8. Output irq_req_o[n] equals pending flag n.
- R8: A write to offset 4 clears each flag whose data bit is 0 and leaves each flag whose data bit is 1 unchanged. A pending flag changes from 1 to 0 only through such a write.
- R9: If a detected event and a clear of the same flag fall in the same clock, the flag ends set.
- R10: The NMI register at offset 0 reports the following, and all its other bits read 0:
  - bit 15: the synchronized NMI pin level, read-only.
  - bit 8: the edge select, read/write, where 0 means falling and 1 means rising.
  - bit 1: the NMI flag.
- R11: The NMI flag is set on the selected NMI edge and is driven on nmi_req_o. It clears only when a write to offset 0 has bit 1 at 0. A write with bit 1 at 1 keeps it.
- R12: Changing a pin just after a clock edge makes the resulting flag visible after the third following rising edge, and not after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_pin_i | input | 8 | Asynchronous external interrupt pins |
| nmi_pin_i | input | 1 | Asynchronous non-maskable interrupt pin |
| bus_sel_i | input | 1 | Register access strobe |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 3 | Byte offset of the register |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for bus_addr_i (combinational) |
| irq_req_o | output | 8 | Per-pin request lines to the parent controller |
| nmi_req_o | output | 1 | NMI request line |

## Verification
The case that needs care is a software clear of a pending flag that lands in the same clock as a fresh edge on that pin, where the edge must win. The bench provokes this directly. It counts the three register stages between pin and flag and places the clearing write on exactly the edge where the second falling transition is detected. It then expects the flag to read as still set. A long random phase toggles pins and issues clears, sense changes and NMI writes at random. Many same-cycle collisions arise there, and a bench model built from the requirements judges every cycle's flags and read data.

// File: rtl/eirq_pkg.sv
package eirq_pkg;
  typedef enum logic [1:0] {
    SNS_LOW  = 2'd0,
    SNS_FALL = 2'd1,
    SNS_RISE = 2'd2,
    SNS_BOTH = 2'd3
  } sense_e;

  localparam int OFF_NMI   = 0;
  localparam int OFF_SENSE = 2;
  localparam int OFF_REQ   = 4;

  localparam int NMI_LVL_BIT  = 15;
  localparam int NMI_EDGE_BIT = 8;
  localparam int NMI_FLAG_BIT = 1;
endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  // reset to idle-high so no edge or level is seen out of reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '1;
      s2_q <= '1;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/eirq_detect.sv
module eirq_detect
  import eirq_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   lvl_i,
  input  sense_e mode_i,
  output logic   evt_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= lvl_i;
  end

  always_comb begin
    unique case (mode_i)
      SNS_LOW:  evt_o = ~lvl_i;
      SNS_FALL: evt_o = prev_q & ~lvl_i;
      SNS_RISE: evt_o = ~prev_q & lvl_i;
      SNS_BOTH: evt_o = prev_q ^ lvl_i;
      default:  evt_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
  import eirq_pkg::*;
#(
  parameter int NUM_IRQ = 8,
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_IRQ-1:0] irq_pin_i,
  input  logic               nmi_pin_i,
  input  logic               bus_sel_i,
  input  logic               bus_wr_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic [DATA_W-1:0]  bus_wdata_i,
  output logic [DATA_W-1:0]  bus_rdata_o,
  output logic [NUM_IRQ-1:0] irq_req_o,
  output logic               nmi_req_o
);
  localparam int NUM_IN  = NUM_IRQ + 1;
  localparam int SENSE_W = 2 * NUM_IRQ;

  logic [NUM_IN-1:0]  pins_sync;
  logic [NUM_IRQ-1:0] irq_lvl, irq_evt, pend_q, req_clr;
  logic [SENSE_W-1:0] sense_q;
  logic               nmi_lvl, nmi_evt, nmi_edge_q, nmi_flag_q, nmi_clr;
  sense_e             nmi_mode;
  logic               acc_nmi, acc_sense, acc_req;
  logic               wr_nmi, wr_sense, wr_req;

  eirq_sync #(.W(NUM_IN)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({nmi_pin_i, irq_pin_i}),
    .q_o    (pins_sync)
  );

  assign irq_lvl = pins_sync[NUM_IRQ-1:0];
  assign nmi_lvl = pins_sync[NUM_IRQ];

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_irq
    eirq_detect u_det (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .lvl_i  (irq_lvl[g]),
      .mode_i (sense_e'(sense_q[2*g +: 2])),
      .evt_o  (irq_evt[g])
    );
  end

  assign nmi_mode = nmi_edge_q ? SNS_RISE : SNS_FALL;

  eirq_detect u_nmi_det (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (nmi_lvl),
    .mode_i (nmi_mode),
    .evt_o  (nmi_evt)
  );

  assign acc_nmi   = (bus_addr_i == ADDR_W'(OFF_NMI));
  assign acc_sense = (bus_addr_i == ADDR_W'(OFF_SENSE));
  assign acc_req   = (bus_addr_i == ADDR_W'(OFF_REQ));
  assign wr_nmi    = bus_sel_i & bus_wr_i & acc_nmi;
  assign wr_sense  = bus_sel_i & bus_wr_i & acc_sense;
  assign wr_req    = bus_sel_i & bus_wr_i & acc_req;

  // write-0-to-clear; a same-cycle event wins
  assign req_clr = wr_req ? ~bus_wdata_i[NUM_IRQ-1:0] : '0;
  assign nmi_clr = wr_nmi & ~bus_wdata_i[NMI_FLAG_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q     <= '0;
      sense_q    <= '0;
      nmi_edge_q <= 1'b0;
      nmi_flag_q <= 1'b0;
    end else begin
      pend_q     <= (pend_q & ~req_clr) | irq_evt;
      nmi_flag_q <= (nmi_flag_q & ~nmi_clr) | nmi_evt;
      if (wr_sense) sense_q    <= bus_wdata_i[SENSE_W-1:0];
      if (wr_nmi)   nmi_edge_q <= bus_wdata_i[NMI_EDGE_BIT];
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    if (acc_nmi) begin
      bus_rdata_o[NMI_LVL_BIT]  = nmi_lvl;
      bus_rdata_o[NMI_EDGE_BIT] = nmi_edge_q;
      bus_rdata_o[NMI_FLAG_BIT] = nmi_flag_q;
    end else if (acc_sense) begin
      bus_rdata_o[SENSE_W-1:0] = sense_q;
    end else if (acc_req) begin
      bus_rdata_o[NUM_IRQ-1:0] = pend_q;
    end
  end

  assign irq_req_o = pend_q;
  assign nmi_req_o = nmi_flag_q;
endmodule

// File: rtl/eirq_checker.sv
module eirq_checker #(
  parameter int NUM_IRQ = 8,
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 3
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 bus_sel_i,
  input logic                 bus_wr_i,
  input logic [ADDR_W-1:0]    bus_addr_i,
  input logic [DATA_W-1:0]    bus_wdata_i,
  input logic [DATA_W-1:0]    bus_rdata_o,
  input logic [NUM_IRQ-1:0]   irq_req_o,
  input logic                 nmi_req_o,
  input logic [2*NUM_IRQ-1:0] sense_i,
  input logic [NUM_IRQ-1:0]   lvl_i
);
  logic [NUM_IRQ-1:0] low_act;
  logic               wr_req_any, wr_req_keep_all, wr_nmi_clr;

  always_comb begin
    for (int n = 0; n < NUM_IRQ; n++)
      low_act[n] = (sense_i[2*n +: 2] == 2'd0) && !lvl_i[n];
  end

  assign wr_req_any      = bus_sel_i && bus_wr_i && (bus_addr_i == ADDR_W'(4));
  assign wr_req_keep_all = !wr_req_any || (bus_wdata_i[NUM_IRQ-1:0] == '1);
  assign wr_nmi_clr      = bus_sel_i && bus_wr_i && (bus_addr_i == ADDR_W'(0)) && !bus_wdata_i[1];

  AST_LEVEL_RESETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (low_act != '0) |=> ((irq_req_o & $past(low_act)) == $past(low_act))); // R3

  AST_REQ_READBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_addr_i == ADDR_W'(4)) |->
      (bus_rdata_o[NUM_IRQ-1:0] == irq_req_o) && (bus_rdata_o[DATA_W-1:NUM_IRQ] == '0)); // R7

  AST_NO_STRAY_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_keep_all |=> (($past(irq_req_o) & ~irq_req_o) == '0)); // R8

  AST_NMI_CTRL_MAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_addr_i == ADDR_W'(0)) |->
      ((bus_rdata_o & ~DATA_W'(16'h8102)) == '0) && (bus_rdata_o[1] == nmi_req_o)); // R10

  AST_NMI_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_nmi_clr |=> !$fell(nmi_req_o)); // R11
endmodule

bind ext_irq_sense eirq_checker #(
  .NUM_IRQ (NUM_IRQ),
  .DATA_W  (DATA_W),
  .ADDR_W  (ADDR_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_sel_i   (bus_sel_i),
  .bus_wr_i    (bus_wr_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .bus_rdata_o (bus_rdata_o),
  .irq_req_o   (irq_req_o),
  .nmi_req_o   (nmi_req_o),
  .sense_i     (sense_q),
  .lvl_i       (irq_lvl)
);

// File: tb/ext_irq_sense_tb.sv
`timescale 1ns/1ps
module ext_irq_sense_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  irq_pin = 8'hFF;
  logic        nmi_pin = 1'b1;
  logic        sel = 1'b0, wr = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [15:0] wdata = 16'h0;
  logic [15:0] rdata;
  logic [7:0]  irq_req;
  logic        nmi_req;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  ext_irq_sense u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .irq_pin_i   (irq_pin),
    .nmi_pin_i   (nmi_pin),
    .bus_sel_i   (sel),
    .bus_wr_i    (wr),
    .bus_addr_i  (addr),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .irq_req_o   (irq_req),
    .nmi_req_o   (nmi_req)
  );

  // reference model built from the requirements
  logic [8:0]  m_s1, m_s2, m_p;
  logic [7:0]  m_pend;
  logic [15:0] m_sense;
  logic        m_edge, m_nflag;

  function automatic logic sense_hit(logic [1:0] md, logic s, logic p);
    case (md)
      2'd0:    return !s;
      2'd1:    return p && !s;
      2'd2:    return !p && s;
      default: return p != s;
    endcase
  endfunction

  function automatic logic [15:0] exp_read(logic [2:0] a);
    case (a)
      3'd0:    return {m_s2[8], 6'b0, m_edge, 6'b0, m_nflag, 1'b0};
      3'd2:    return m_sense;
      3'd4:    return {8'h00, m_pend};
      default: return 16'h0000;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= '1; m_s2 <= '1; m_p <= '1;
      m_pend <= '0; m_sense <= '0; m_edge <= 1'b0; m_nflag <= 1'b0;
    end else begin
      logic [7:0] ev, clr;
      logic nev, nclr;
      for (int n = 0; n < 8; n++) ev[n] = sense_hit(m_sense[2*n +: 2], m_s2[n], m_p[n]);
      nev  = m_edge ? (!m_p[8] && m_s2[8]) : (m_p[8] && !m_s2[8]);
      clr  = (sel && wr && addr == 3'd4) ? ~wdata[7:0] : 8'h00;
      nclr = sel && wr && addr == 3'd0 && !wdata[1];
      m_pend  <= (m_pend & ~clr) | ev;
      m_nflag <= (m_nflag && !nclr) || nev;
      if (sel && wr && addr == 3'd2) m_sense <= wdata;
      if (sel && wr && addr == 3'd0) m_edge  <= wdata[8];
      m_p  <= m_s2;
      m_s2 <= m_s1;
      m_s1 <= {nmi_pin, irq_pin};
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic wr_reg(logic [2:0] a, logic [15:0] d);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic rd_chk(logic [2:0] a, logic [15:0] exp, string tag);
    sel = 1'b1; wr = 1'b0; addr = a;
    #1;
    chk(tag, rdata, exp);
    sel = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0421));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq_req", irq_req, 8'h00);
    chk("R1 nmi_req", nmi_req, 1'b0);
    rd_chk(3'd4, 16'h0000, "R1 req reg");
    rd_chk(3'd2, 16'h0000, "R1 sense reg");
    rd_chk(3'd0, 16'h8000, "R1 nmi reg");

    // R2: pin n gets code n%4
    wr_reg(3'd2, 16'hE4E4);
    rd_chk(3'd2, 16'hE4E4, "R2 sense readback");

    // R12 / R4: falling edge on pin 1
    irq_pin[1] = 1'b0;
    step(2);
    chk("R12 not after two edges", irq_req, 8'h00);
    step(1);
    chk("R12 R4 falling sets", irq_req, 8'h02);
    irq_pin[1] = 1'b1;
    wr_reg(3'd4, 16'hFFFF);
    chk("R8 ones keep", irq_req, 8'h02);
    wr_reg(3'd4, 16'hFFFD);
    chk("R8 zero clears", irq_req, 8'h00);

    // R5 rising on pin 2
    irq_pin[2] = 1'b0;
    step(4);
    chk("R5 no set on fall", irq_req, 8'h00);
    irq_pin[2] = 1'b1;
    step(3);
    chk("R5 rising sets", irq_req, 8'h04);
    wr_reg(3'd4, 16'hFFFB);

    // R6 both edges on pin 3
    irq_pin[3] = 1'b0;
    step(3);
    chk("R6 fall sets", irq_req, 8'h08);
    wr_reg(3'd4, 16'hFFF7);
    chk("R6 cleared", irq_req, 8'h00);
    irq_pin[3] = 1'b1;
    step(3);
    chk("R6 rise sets", irq_req, 8'h08);
    wr_reg(3'd4, 16'hFFF7);

    // R3 low level on pin 0
    irq_pin[0] = 1'b0;
    step(3);
    chk("R3 low sets", irq_req, 8'h01);
    wr_reg(3'd4, 16'hFFFE);
    chk("R3 clear while low no effect", irq_req, 8'h01);
    irq_pin[0] = 1'b1;
    step(3);
    wr_reg(3'd4, 16'hFFFE);
    chk("R3 clear after release", irq_req, 8'h00);

    // R9 event and clear in the same cycle on pin 5 (falling)
    irq_pin[5] = 1'b0;
    step(3);
    chk("R9 setup pending", irq_req, 8'h20);
    irq_pin[5] = 1'b1;
    step(3);
    irq_pin[5] = 1'b0;
    step(2);
    wr_reg(3'd4, 16'hFFDF);
    chk("R9 event wins over clear", irq_req, 8'h20);
    wr_reg(3'd4, 16'hFFDF);
    chk("R9 later clear works", irq_req, 8'h00);
    irq_pin[5] = 1'b1;

    // R7 register view on pin 4 (low level)
    irq_pin[4] = 1'b0;
    step(3);
    rd_chk(3'd4, 16'h0010, "R7 req reg view");
    chk("R7 line", irq_req, 8'h10);
    irq_pin[4] = 1'b1;
    step(3);
    wr_reg(3'd4, 16'hFFEF);
    chk("R7 cleared", irq_req, 8'h00);

    // R10 / R11 NMI
    wr_reg(3'd0, 16'h0100);
    rd_chk(3'd0, 16'h8100, "R10 edge select readback");
    nmi_pin = 1'b0;
    step(3);
    chk("R11 no flag on fall in rising mode", nmi_req, 1'b0);
    rd_chk(3'd0, 16'h0100, "R10 level low");
    nmi_pin = 1'b1;
    step(3);
    chk("R11 rising sets flag", nmi_req, 1'b1);
    rd_chk(3'd0, 16'h8102, "R10 flag view");
    wr_reg(3'd0, 16'hFFFF);
    rd_chk(3'd0, 16'h8102, "R11 writing one keeps");
    wr_reg(3'd0, 16'h0100);
    rd_chk(3'd0, 16'h8100, "R11 writing zero clears");
    wr_reg(3'd0, 16'h0000);
    nmi_pin = 1'b0;
    step(3);
    chk("R10 falling select", nmi_req, 1'b1);
    wr_reg(3'd0, 16'h0000);
    rd_chk(3'd0, 16'h0000, "R11 cleared, level low");
    nmi_pin = 1'b1;
    step(3);

    // random phase against the model
    for (int i = 0; i < 4000; i++) begin
      logic [2:0] ra;
      ra = ($urandom % 4 == 0) ? 3'($urandom % 8) : 3'(2 * ($urandom % 3));
      sel = 1'b1; wr = 1'b0; addr = ra;
      #1;
      chk("R2 R7 R10 random read", rdata, exp_read(ra));
      chk("R3 R4 R5 R6 R8 R9 random lines", irq_req, m_pend);
      chk("R11 random nmi", nmi_req, m_nflag);
      for (int b = 0; b < 8; b++) if ($urandom % 10 == 0) irq_pin[b] = ~irq_pin[b];
      if ($urandom % 12 == 0) nmi_pin = ~nmi_pin;
      if ($urandom % 5 == 0) begin
        logic [2:0] wa;
        wa = 3'(2 * ($urandom % 3));
        wr = 1'b1; addr = wa;
        if (wa == 3'd4 && ($urandom % 2 == 0)) wdata = ~(16'h1 << ($urandom % 8));
        else wdata = 16'($urandom);
      end
      @(posedge clk); @(negedge clk);
      wr = 1'b0;
    end
    sel = 1'b0;

    done = 1'b1;
    summary();
    $finish;
  end
endmodule